// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether a frame is kept or dropped from the first twelve header bytes: the destination address followed by the source address. The bytes arrive one per cycle on a small byte stream, with a start flag on the first byte and a valid qualifier. Idle cycles between bytes are allowed.

While the destination bytes go by, a byte-wide reflected CRC-32 engine folds them in. Its six most significant result bits form an index into a 64-bit multicast filter, which a host loads as four 16-bit words. The same stream is compared byte by byte against a programmed station address. A promiscuous control and a reject-own-source control complete the policy. One cycle after the twelfth byte is taken, a single-cycle strobe presents the accept decision and the filter index that was computed.

The host writes the configuration through a simple write port: a write enable, a 3-bit register select and 16 bits of data. There is no read-back path, and every setting is seen only through later decisions.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_index` are 0, all four filter words are clear, and the station address, promiscuous control and reject-own control are all 0.
- R2: `dec_index` equals bits 31..26 of a CRC-32 that is preset to all ones and then steps over destination bytes 0..5 in arrival order. Each byte is taken LSB first. On each bit, if CRC bit 0 XOR the data bit is 1, the CRC shifts right and is XORed with 0xEDB88320; otherwise it only shifts right. No final inversion is applied.
- R3: A destination with bit 0 of byte 0 set, other than broadcast, is accepted exactly when bit `dec_index[3:0]` of filter word `dec_index[5:4]` is 1. Filter word k is written at register select k (k = 0..3).
- R4: With all four filter words at 0xFFFF every multicast destination is accepted, and with all four at 0 every multicast destination is rejected.
- R5: A destination of all ones (broadcast) is accepted whatever the filter holds.
- R6: A destination with bit 0 of byte 0 clear is accepted only when all six bytes equal the station address. Station word j is written at select 4+j and holds address byte 2j in bits 7..0 and byte 2j+1 in bits 15..8.
- R7: When the promiscuous control (bit 0 of the register at select 7) is 1, every frame is accepted, including frames whose source matches the station address.
- R8: When the reject-own control (bit 1 at select 7) is 1 and promiscuous is 0, a frame whose six source bytes equal the station address is rejected, even when it is broadcast or passes the filter.
- R9: `dec_valid` is a single-cycle pulse. It is high in the cycle after the twelfth header byte is taken and low at every other time. Cycles with `hdr_valid` low neither advance nor disturb the frame.
- R10: A byte with `hdr_sof` high restarts the frame as byte 0 and discards a partial frame. Bytes with `hdr_valid` high after the twelfth byte and before the next `hdr_sof` are ignored.
- R11: A configuration write takes effect at the clock edge that samples it and governs the decision of every frame that completes after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 0..3 filter words, 4..6 station words, 7 control |
| cfg_wdata | input | 16 | Configuration write data |
| hdr_valid | input | 1 | Header byte present this cycle |
| hdr_sof | input | 1 | Marks the first header byte of a frame |
| hdr_byte | input | 8 | Header byte, destination bytes 0..5 then source bytes 0..5 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted, meaningful with dec_valid |
| dec_index | output | 6 | Filter index of the destination, meaningful with dec_valid |

## Verification
A CRC register that is seeded wrongly, or that steps on a bit in the wrong order, shows up at the end of the very next frame as a `dec_index` that differs from the one computed in the bench. It can also flip `dec_accept` when the filter holds a single set bit. A byte counter that slips, or that counts an idle cycle, moves or drops the `dec_valid` strobe. The bench compares that strobe at every clock of every frame, so such a fault is reported within one header time. A wrong comparison flag or a wrong priority between the controls shows only on frames built for that case: own-source frames, broadcast and unicast frames are each sent with the controls switched both ways.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int HASH_WORDS = 4;
    localparam int WORD_W     = 16;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int STN_WORDS  = ADDR_W / WORD_W;
    localparam int FILT_BITS  = HASH_WORDS * WORD_W;
    localparam int IDX_W      = $clog2(FILT_BITS);
    localparam int HDR_BYTES  = 2 * ADDR_BYTES;
    localparam int CNT_W      = $clog2(HDR_BYTES + 1);
    localparam int CFG_AW     = 3;
    localparam int STN_BASE   = HASH_WORDS;
    localparam int CTRL_SEL   = STN_BASE + STN_WORDS;

    // Running comparison results for one header.
    typedef struct packed {
        logic dst_eq;   // destination equals station so far
        logic src_eq;   // source equals station so far
        logic bcast;    // destination all ones so far
        logic mcast;    // group bit of destination byte 0
    } addr_flags_t;

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
    import mhf_pkg::*;
#(
    parameter int                W    = CRC_W,
    parameter logic [CRC_W-1:0]  POLY = CRC_POLY,
    parameter int                BW   = BYTE_W,
    parameter int                OW   = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_en,
    input  logic          restart,
    input  logic [BW-1:0] byte_in,
    output logic [OW-1:0] idx_out
);

    typedef struct packed {
        logic [W-1:0] crc;
    } crc_state_t;

    crc_state_t s_d, s_q;

    function automatic logic [W-1:0] step_byte(input logic [W-1:0] seed,
                                               input logic [BW-1:0] din);
        logic [W-1:0] c;
        c = seed;
        for (int b = 0; b < BW; b++) begin
            if (c[0] ^ din[b]) c = (c >> 1) ^ POLY[W-1:0];
            else               c = c >> 1;
        end
        return c;
    endfunction

    always_comb begin
        logic [W-1:0] seed;
        s_d  = s_q;
        seed = restart ? {W{1'b1}} : s_q.crc;
        if (byte_en) s_d.crc = step_byte(seed, byte_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{crc: {W{1'b1}}};
        else        s_q <= s_d;
    end

    assign idx_out = s_q.crc[W-1 -: OW];

    assert_crc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(s_q.crc));

endmodule

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs
    import mhf_pkg::*;
#(
    parameter int NH  = HASH_WORDS,
    parameter int NS  = STN_WORDS,
    parameter int WW  = WORD_W,
    parameter int AW  = CFG_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WW-1:0]    cfg_wdata,
    output logic [NH*WW-1:0] hash_flat,
    output logic [NS*WW-1:0] station,
    output logic             promisc,
    output logic             rej_own
);

    localparam int SBASE = NH;
    localparam int CSEL  = NH + NS;

    typedef struct packed {
        logic [NH-1:0][WW-1:0] hash;
        logic [NS-1:0][WW-1:0] stn;
        logic                  promisc;
        logic                  rej_own;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            for (int k = 0; k < NH; k++) begin
                if (cfg_addr == AW'(k)) s_d.hash[k] = cfg_wdata;
            end
            for (int j = 0; j < NS; j++) begin
                if (cfg_addr == AW'(SBASE + j)) s_d.stn[j] = cfg_wdata;
            end
            if (cfg_addr == AW'(CSEL)) begin
                s_d.promisc = cfg_wdata[0];
                s_d.rej_own = cfg_wdata[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NH; g++) begin : g_hash_out
        assign hash_flat[g*WW +: WW] = s_q.hash[g];
    end
    for (genvar g = 0; g < NS; g++) begin : g_stn_out
        assign station[g*WW +: WW] = s_q.stn[g];
    end
    assign promisc = s_q.promisc;
    assign rej_own = s_q.rej_own;

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(s_q));

endmodule

// File: rtl/mhf_addr_cmp.sv
module mhf_addr_cmp
    import mhf_pkg::*;
#(
    parameter int NB = ADDR_BYTES,
    parameter int BW = BYTE_W,
    parameter int CW = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           byte_en,
    input  logic           sof,
    input  logic [CW-1:0]  pos,
    input  logic [BW-1:0]  byte_in,
    input  logic [NB*BW-1:0] station,
    output addr_flags_t    flags_nxt
);

    typedef struct packed {
        addr_flags_t f;
    } cmp_state_t;

    cmp_state_t s_d, s_q;

    always_comb begin
        logic [BW-1:0] ref_b;
        logic          in_dst;
        logic          hit;
        logic          ones;
        s_d    = s_q;
        in_dst = (pos < CW'(NB));
        ref_b  = '0;
        for (int k = 0; k < NB; k++) begin
            if (in_dst  && pos == CW'(k))      ref_b = station[k*BW +: BW];
            if (!in_dst && pos == CW'(k + NB)) ref_b = station[k*BW +: BW];
        end
        hit  = (byte_in == ref_b);
        ones = (byte_in == {BW{1'b1}});
        if (byte_en) begin
            if (sof) begin
                s_d.f.dst_eq = hit;
                s_d.f.src_eq = 1'b1;
                s_d.f.bcast  = ones;
                s_d.f.mcast  = byte_in[0];
            end else if (in_dst) begin
                s_d.f.dst_eq = s_q.f.dst_eq & hit;
                s_d.f.bcast  = s_q.f.bcast & ones;
            end else begin
                s_d.f.src_eq = s_q.f.src_eq & hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_nxt = s_d.f;

    assert_group_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && !sof && pos != '0) |=> $stable(s_q.f.mcast));

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              hdr_valid,
    input  logic              hdr_sof,
    input  logic [BYTE_W-1:0] hdr_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [IDX_W-1:0]  dec_index
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             valid;
        logic             accept;
        logic [IDX_W-1:0] index;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [FILT_BITS-1:0] hash_flat;
    logic [ADDR_W-1:0]    station;
    logic                 promisc;
    logic                 rej_own;
    logic [IDX_W-1:0]     crc_idx;
    addr_flags_t          flags_nxt;

    logic             take;
    logic [CNT_W-1:0] pos;
    logic             last_evt;
    logic             crc_en;

    assign take     = hdr_valid && (hdr_sof || s_q.active);
    assign pos      = hdr_sof ? '0 : s_q.cnt;
    assign last_evt = take && (pos == CNT_W'(HDR_BYTES - 1));
    assign crc_en   = take && (pos < CNT_W'(ADDR_BYTES));

    mhf_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hash_flat (hash_flat),
        .station   (station),
        .promisc   (promisc),
        .rej_own   (rej_own)
    );

    mhf_crc_engine u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_en (crc_en),
        .restart (hdr_sof),
        .byte_in (hdr_byte),
        .idx_out (crc_idx)
    );

    mhf_addr_cmp u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_en   (take),
        .sof       (hdr_sof),
        .pos       (pos),
        .byte_in   (hdr_byte),
        .station   (station),
        .flags_nxt (flags_nxt)
    );

    function automatic logic decide(input addr_flags_t f,
                                    input logic p, input logic r,
                                    input logic filt_hit);
        if (p)               return 1'b1;
        if (r && f.src_eq)   return 1'b0;
        if (f.bcast)         return 1'b1;
        if (f.mcast)         return filt_hit;
        return f.dst_eq;
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (take) begin
            s_d.cnt    = pos + CNT_W'(1);
            s_d.active = !last_evt;
        end
        if (last_evt) begin
            s_d.valid  = 1'b1;
            s_d.accept = decide(flags_nxt, promisc, rej_own, hash_flat[crc_idx]);
            s_d.index  = crc_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dec_valid  = s_q.valid;
    assign dec_accept = s_q.accept;
    assign dec_index  = s_q.index;

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_strobe_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last_evt |=> dec_valid);

    assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_evt && promisc) |=> dec_accept);

    assert_own_source_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_evt && !promisc && rej_own && flags_nxt.src_eq) |=> !dec_accept);

    assert_broadcast_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_evt && !(rej_own && flags_nxt.src_eq) && flags_nxt.bcast) |=> dec_accept);

    assert_unicast_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_evt && !promisc && !flags_nxt.mcast && !flags_nxt.dst_eq) |=> !dec_accept);

    assert_full_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_evt && flags_nxt.mcast && (&hash_flat)) |=> dec_accept || $past(rej_own));

endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        hdr_valid;
    logic        hdr_sof;
    logic [7:0]  hdr_byte;
    logic        dec_valid;
    logic        dec_accept;
    logic [5:0]  dec_index;

    int tests_run = 0;
    int tests_failed = 0;

    // Behavioural mirror of the host-visible configuration.
    logic [15:0] m_hash [4];
    logic [47:0] m_stn;
    logic        m_promisc;
    logic        m_rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcast_hash_filter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .hdr_valid  (hdr_valid),
        .hdr_sof    (hdr_sof),
        .hdr_byte   (hdr_byte),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_index  (dec_index)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic logic [5:0] ref_idx(input logic [47:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] d, input logic [47:0] s);
        logic [5:0] ix;
        ix = ref_idx(d);
        if (m_promisc)              return 1'b1;
        if (m_rej && s == m_stn)    return 1'b0;
        if (d == 48'hFFFFFFFFFFFF)  return 1'b1;
        if (d[0])                   return m_hash[ix[5:4]][ix[3:0]];
        return d == m_stn;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [15:0] v);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 3'd4)       m_hash[a[1:0]] = v;
        else if (a < 3'd7)  m_stn[16*(a-3'd4) +: 16] = v;
        else begin m_promisc = v[0]; m_rej = v[1]; end
    endtask

    task automatic set_hash_all(input logic [15:0] v);
        for (int k = 0; k < 4; k++) cfg_write(3'(k), v);
    endtask

    // Called at a negedge; checks the strobe at every clock of the frame.
    task automatic send_frame(input string req, input logic [47:0] d,
                              input logic [47:0] s, input int gap);
        logic exp_acc;
        logic [5:0] exp_ix;
        exp_acc = ref_accept(d, s);
        exp_ix  = ref_idx(d);
        for (int i = 0; i < 12; i++) begin
            hdr_valid = 1'b1;
            hdr_sof   = (i == 0);
            hdr_byte  = (i < 6) ? d[8*i +: 8] : s[8*(i-6) +: 8];
            @(negedge clk);
            hdr_valid = 1'b0;
            hdr_sof   = 1'b0;
            if (i == 11) begin
                check({req, " R9 strobe"}, dec_valid, 1);
                check({req, " accept"}, dec_accept, exp_acc);
                check({req, " R2 index"}, dec_index, exp_ix);
            end else begin
                check({req, " R9 no early strobe"}, dec_valid, 0);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    check({req, " R9 idle gap"}, dec_valid, 0);
                end
            end
        end
        @(negedge clk);
        check({req, " R9 single pulse"}, dec_valid, 0);
    endtask

    logic [47:0] stn, ma, mb, uni_other, src_x;
    logic [5:0]  ia;

    initial begin
        #(CLK_PERIOD * 150000);
        tests_failed++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        hdr_valid = 1'b0; hdr_sof = 1'b0; hdr_byte = '0;
        for (int k = 0; k < 4; k++) m_hash[k] = '0;
        m_stn = '0; m_promisc = 1'b0; m_rej = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 reset valid", dec_valid, 0);
        check("R1 reset accept", dec_accept, 0);
        check("R1 reset index", dec_index, 0);

        stn       = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        ma        = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
        mb        = mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'hFB);
        uni_other = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
        src_x     = mk(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F);

        // R1/R4: cleared filter after reset rejects multicast.
        send_frame("R1 R4 cleared filter", ma, src_x, 0);

        // R4: full filter accepts any multicast.
        set_hash_all(16'hFFFF);
        send_frame("R4 full filter a", ma, src_x, 0);
        send_frame("R4 full filter b", mb, src_x, 0);
        send_frame("R4 full filter c", mk(8'hAB, 8'hCD, 8'hEF, 8'h01, 8'h23, 8'h45), src_x, 0);

        // R3: exactly one bit set, matching ma's index.
        set_hash_all(16'h0000);
        ia = ref_idx(ma);
        cfg_write(3'(ia[5:4]), 16'(1) << ia[3:0]);
        send_frame("R3 single bit hit", ma, src_x, 0);
        send_frame("R3 single bit other", mb, src_x, 0);
        send_frame("R3 R4 cleared other", mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h00), src_x, 0);

        // R5: broadcast with zero filter.
        set_hash_all(16'h0000);
        send_frame("R5 broadcast", 48'hFFFFFFFFFFFF, src_x, 0);

        // R6: unicast match and mismatch.
        for (int j = 0; j < 3; j++) cfg_write(3'(4 + j), stn[16*j +: 16]);
        send_frame("R6 unicast match", stn, src_x, 0);
        send_frame("R6 unicast mismatch", uni_other, src_x, 0);

        // R8: reject own source, even broadcast.
        cfg_write(3'd7, 16'h0002);
        send_frame("R8 own source broadcast", 48'hFFFFFFFFFFFF, stn, 0);
        send_frame("R8 own source unicast", stn, stn, 0);
        send_frame("R8 foreign source", stn, src_x, 0);

        // R7: promiscuous overrides everything.
        cfg_write(3'd7, 16'h0003);
        send_frame("R7 promisc own source", uni_other, stn, 0);
        send_frame("R7 promisc multicast", mb, src_x, 0);

        // R11: clearing control takes effect for the next frame.
        cfg_write(3'd7, 16'h0000);
        send_frame("R11 after control clear", uni_other, src_x, 0);
        set_hash_all(16'hFFFF);
        send_frame("R11 after filter set", mb, src_x, 0);

        // R9: idle cycles inside the header.
        send_frame("R9 gapped frame", ma, src_x, 2);
        set_hash_all(16'h0000);
        send_frame("R9 gapped reject", ma, src_x, 1);

        // R10: partial frame discarded by a new start.
        hdr_valid = 1'b1; hdr_sof = 1'b1; hdr_byte = 8'hFF;
        @(negedge clk);
        hdr_sof = 1'b0;
        for (int i = 0; i < 4; i++) begin
            hdr_byte = 8'hFF;
            @(negedge clk);
            check("R10 partial no strobe", dec_valid, 0);
        end
        hdr_valid = 1'b0;
        send_frame("R10 restart", stn, src_x, 0);

        // R10: trailing bytes without a start are ignored.
        for (int i = 0; i < 14; i++) begin
            hdr_valid = 1'b1; hdr_sof = 1'b0; hdr_byte = 8'h5A;
            @(negedge clk);
            check("R10 trailing ignored", dec_valid, 0);
        end
        hdr_valid = 1'b0;
        @(negedge clk);
        check("R10 trailing ignored final", dec_valid, 0);
        send_frame("R10 next frame", uni_other, src_x, 0);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule